// File: doc/BRIEF.md
# Four-Entry Instruction Translation Buffer with Pairwise-LRU Refill

This block is a small, fully associative translation buffer that sits on the instruction fetch path. Each fetch presents a virtual page number, the current address-space identifier (ASID) and a flag that says whether the ASID takes part in matching. The four entries are compared in parallel. A single match reports a hit and the entry index. Two or more matches report a multi-hit. No match reports a miss.

When refill is allowed, a miss raises a combinational lookup request to a larger unified translation buffer. If that buffer answers with one hit, its entry is copied into a victim slot. The fetch then counts as a hit on that slot in the same cycle.

The victim comes from a 6-bit pairwise-order replacement code. Every hit moves the touched entry to most-recently-used. The code sits in bits 31:26 of a 32-bit control word that can be read at any time and loaded with a write strobe. The unified buffer and the page-table walk are outside this block.

Top module: `itlb_refill`

## Requirements
- R1: After reset all four entries are invalid, the replacement code is 000000, and the control word reads 0.
- R2: An entry matches only when it is valid, its page number equals the fetch page number, and at least one of these holds: the entry is shared, ASID matching is off, or its ASID equals the current ASID.
- R3: With more than one matching entry, `multi_hit` is 1 and `hit`, `miss` and `ut_req` are 0. Neither the entries nor the replacement code change.
- R4: A hit updates the code L[5:0] (control bits 31:26) as follows. Entry 0 clears L5, L4 and L3. Entry 1 sets L5 and clears L2 and L1. Entry 2 sets L4 and L2 and clears L0. Entry 3 sets L3, L1 and L0. All other bits are kept.
- R5: The victim is decoded in this priority order. Entry 0 when L5, L4 and L3 are all 1. Else entry 1 when L5=0 and L2=L1=1. Else entry 2 when L4=0, L2=0 and L0=1. Else entry 3 when L3, L1 and L0 are all 0.
- R6: On a miss with `refill_en`=1, `ut_req` is 1 and `ut_vpn` equals the fetch page number. A unified hit without a unified multi-hit writes the supplied entry (valid, shared flag, ASID, page number) into the victim slot. It also reports `hit` with `hit_idx` equal to the victim and applies the R4 update for that slot.
- R7: A miss with `refill_en`=0, or a unified miss, reports `miss` and writes no entry. With `refill_en`=0, `ut_req` stays 0.
- R8: A code that matches none of the R5 patterns selects entry 0 as victim and drives `lru_err` to 1. For legal codes `lru_err` is 0.
- R9: A `ctrl_we` pulse loads `ctrl_wcode` into the code, taking precedence over a same-cycle hit update. Control bits 25:0 always read 0.
- R10: A unified multi-hit during a refill reports `multi_hit` and writes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fetch lookup is presented this cycle |
| req_vpn | input | VPN_W | Fetch virtual page number |
| cur_asid | input | ASID_W | Current address-space identifier |
| asid_en | input | 1 | 1: the ASID takes part in matching |
| refill_en | input | 1 | 1: a miss may be refilled from the unified buffer |
| ut_req | output | 1 | Lookup request to the unified buffer |
| ut_vpn | output | VPN_W | Page number sent with the request |
| ut_hit | input | 1 | Unified buffer found exactly one entry |
| ut_multi | input | 1 | Unified buffer found several entries |
| ut_shared | input | 1 | Shared flag of the returned entry |
| ut_asid | input | ASID_W | ASID of the returned entry |
| hit | output | 1 | Translation found (direct or after refill) |
| hit_idx | output | 2 | Entry that hit |
| miss | output | 1 | Instruction translation miss |
| multi_hit | output | 1 | Several entries matched |
| lru_err | output | 1 | Replacement code is not a legal pattern |
| ctrl_we | input | 1 | Load the replacement code |
| ctrl_wcode | input | 6 | Value for control bits 31:26 |
| ctrl_rdata | output | 32 | Control word, code in bits 31:26 |

## Verification
The bench uses the default widths: a 22-bit page number and an 8-bit ASID. The entry count is fixed at four by the replacement code, so the whole replacement state space is 64 codes. That is small enough to cover completely. For every code, the bench loads the code, forces a refill to reveal the victim and the error flag, and then hits each of the four entries to read back the updated code. Before the sweep, directed sequences build deliberate aliasing between entries. These cover the ASID and shared-flag rules, multi-hits, unified misses and unified multi-hits, and a control write that collides with a hit.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int unsigned ENTRY_N = 4;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned CODE_W  = 6;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // Move entry w to most-recently-used in the pairwise order code.
  function automatic code_t code_touch(code_t c, idx_t w);
    code_t r;
    r = c;
    case (w)
      2'd0: r[5:3] = 3'b000;
      2'd1: begin r[5] = 1'b1; r[2:1] = 2'b00; end
      2'd2: begin r[4] = 1'b1; r[2] = 1'b1; r[0] = 1'b0; end
      default: begin r[3] = 1'b1; r[1] = 1'b1; r[0] = 1'b1; end
    endcase
    return r;
  endfunction

  // Returns {illegal, victim}. Checked in fixed priority order.
  function automatic logic [IDX_W:0] code_victim(code_t c);
    if (c[5:3] == 3'b111)                 return {1'b0, 2'd0};
    else if (!c[5] && c[2:1] == 2'b11)    return {1'b0, 2'd1};
    else if (!c[4] && !c[2] && c[0])      return {1'b0, 2'd2};
    else if (!c[3] && !c[1] && !c[0])     return {1'b0, 2'd3};
    else                                  return {1'b1, 2'd0};
  endfunction
endpackage

// File: rtl/itlb_cam.sv
module itlb_cam
  import itlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 22,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_asid_en,
  input  logic              wr_en,
  input  idx_t              wr_idx,
  input  logic              wr_shared,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  output logic [ENTRY_N-1:0] match_vec
);
  for (genvar g = 0; g < ENTRY_N; g++) begin : g_ent
    logic              e_valid;
    logic              e_shared;
    logic [ASID_W-1:0] e_asid;
    logic [VPN_W-1:0]  e_vpn;
    logic              sel;

    assign sel = wr_en && (wr_idx == idx_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_valid  <= 1'b0;
        e_shared <= 1'b0;
        e_asid   <= '0;
        e_vpn    <= '0;
      end else if (sel) begin
        e_valid  <= 1'b1;
        e_shared <= wr_shared;
        e_asid   <= wr_asid;
        e_vpn    <= wr_vpn;
      end
    end

    assign match_vec[g] = e_valid && (e_vpn == lk_vpn) &&
                          (e_shared || !lk_asid_en || (e_asid == lk_asid));
  end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  touch_en,
  input  idx_t  touch_idx,
  input  logic  ld_en,
  input  code_t ld_code,
  output code_t code,
  output idx_t  victim,
  output logic  illegal
);
  logic [IDX_W:0] dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code <= '0;
    else if (ld_en)    code <= ld_code;
    else if (touch_en) code <= code_touch(code, touch_idx);
  end

  assign dec     = code_victim(code);
  assign victim  = dec[IDX_W-1:0];
  assign illegal = dec[IDX_W];
endmodule

// File: rtl/itlb_refill.sv
module itlb_refill
  import itlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 22,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              asid_en,
  input  logic              refill_en,
  output logic              ut_req,
  output logic [VPN_W-1:0]  ut_vpn,
  input  logic              ut_hit,
  input  logic              ut_multi,
  input  logic              ut_shared,
  input  logic [ASID_W-1:0] ut_asid,
  output logic              hit,
  output logic [1:0]        hit_idx,
  output logic              miss,
  output logic              multi_hit,
  output logic              lru_err,
  input  logic              ctrl_we,
  input  logic [5:0]        ctrl_wcode,
  output logic [CTRL_W-1:0] ctrl_rdata
);
  localparam int unsigned LOW_W = CTRL_W - CODE_W;

  logic [ENTRY_N-1:0] match_vec;
  logic               any_match;
  logic               many_match;
  idx_t               match_idx;
  idx_t               vict_idx;
  code_t              lru_code;
  logic               refill_go;
  logic               ut_many;

  itlb_cam #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vpn     (req_vpn),
    .lk_asid    (cur_asid),
    .lk_asid_en (asid_en),
    .wr_en      (refill_go),
    .wr_idx     (vict_idx),
    .wr_shared  (ut_shared),
    .wr_asid    (ut_asid),
    .wr_vpn     (req_vpn),
    .match_vec  (match_vec)
  );

  always_comb begin
    match_idx = '0;
    for (int i = ENTRY_N - 1; i >= 0; i--) begin
      if (match_vec[i]) match_idx = idx_t'(i);
    end
  end

  assign any_match  = |match_vec;
  assign many_match = (match_vec & (match_vec - 1'b1)) != '0;

  assign ut_req    = req_valid && !any_match && refill_en;
  assign ut_vpn    = req_vpn;
  assign refill_go = ut_req && ut_hit && !ut_multi;
  assign ut_many   = ut_req && ut_multi;

  assign hit       = (req_valid && any_match && !many_match) || refill_go;
  assign hit_idx   = refill_go ? vict_idx : match_idx;
  assign multi_hit = (req_valid && many_match) || ut_many;
  assign miss      = req_valid && !any_match && !refill_go && !ut_many;

  itlb_lru u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (hit),
    .touch_idx (hit_idx),
    .ld_en     (ctrl_we),
    .ld_code   (ctrl_wcode),
    .code      (lru_code),
    .victim    (vict_idx),
    .illegal   (lru_err)
  );

  assign ctrl_rdata = {lru_code, {LOW_W{1'b0}}};
endmodule

// File: rtl/itlb_refill_chk.sv
module itlb_refill_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        hit,
  input logic [1:0]  hit_idx,
  input logic        miss,
  input logic        multi_hit,
  input logic        ut_req,
  input logic        ut_hit,
  input logic        ut_multi,
  input logic        lru_err,
  input logic [1:0]  victim,
  input logic        ctrl_we,
  input logic [5:0]  ctrl_wcode,
  input logic [31:0] ctrl_rdata
);
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, multi_hit})); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !hit && !miss && !multi_hit && !ut_req); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !ctrl_we |=> $stable(ctrl_rdata)); // R4
  AST_TOUCH_E0: assert property (@(posedge clk) disable iff (!rst_n)
    hit && hit_idx == 2'd0 && !ctrl_we |=> ctrl_rdata[31:29] == 3'b000); // R4
  AST_TOUCH_E3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && hit_idx == 2'd3 && !ctrl_we |=> ctrl_rdata[29] && ctrl_rdata[27] && ctrl_rdata[26]); // R4
  AST_REFILL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req && ut_hit && !ut_multi |-> hit && hit_idx == victim); // R6
  AST_UT_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    ut_req && ut_multi |-> multi_hit && !hit); // R10
  AST_ERR_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    lru_err |-> victim == 2'd0); // R8
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_rdata == {$past(ctrl_wcode), 26'b0}); // R9
endmodule

bind itlb_refill itlb_refill_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .hit        (hit),
  .hit_idx    (hit_idx),
  .miss       (miss),
  .multi_hit  (multi_hit),
  .ut_req     (ut_req),
  .ut_hit     (ut_hit),
  .ut_multi   (ut_multi),
  .lru_err    (lru_err),
  .victim     (vict_idx),
  .ctrl_we    (ctrl_we),
  .ctrl_wcode (ctrl_wcode),
  .ctrl_rdata (ctrl_rdata)
);

// File: tb/itlb_refill_test.sv
module itlb_refill_test;
  localparam int VPN_W  = 22;
  localparam int ASID_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [VPN_W-1:0]  req_vpn = '0;
  logic [ASID_W-1:0] cur_asid = '0;
  logic              asid_en = 1'b0;
  logic              refill_en = 1'b0;
  logic              ut_req;
  logic [VPN_W-1:0]  ut_vpn;
  logic              ut_hit = 1'b0;
  logic              ut_multi = 1'b0;
  logic              ut_shared = 1'b0;
  logic [ASID_W-1:0] ut_asid = '0;
  logic              hit;
  logic [1:0]        hit_idx;
  logic              miss;
  logic              multi_hit;
  logic              lru_err;
  logic              ctrl_we = 1'b0;
  logic [5:0]        ctrl_wcode = '0;
  logic [31:0]       ctrl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model
  bit          m_v  [4];
  bit          m_sh [4];
  int          m_as [4];
  int          m_vpn[4];
  logic [5:0]  m_code;
  bit          g_we = 1'b0;
  logic [5:0]  g_wcode = '0;

  always #10 clk = ~clk;

  itlb_refill #(.VPN_W(VPN_W), .ASID_W(ASID_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .cur_asid(cur_asid), .asid_en(asid_en), .refill_en(refill_en),
    .ut_req(ut_req), .ut_vpn(ut_vpn), .ut_hit(ut_hit), .ut_multi(ut_multi),
    .ut_shared(ut_shared), .ut_asid(ut_asid), .hit(hit), .hit_idx(hit_idx),
    .miss(miss), .multi_hit(multi_hit), .lru_err(lru_err),
    .ctrl_we(ctrl_we), .ctrl_wcode(ctrl_wcode), .ctrl_rdata(ctrl_rdata)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Replacement arithmetic restated as care/want masks and set/clear masks.
  function automatic int exp_victim(logic [5:0] c, output bit bad);
    logic [5:0] care [4] = '{6'b111000, 6'b100110, 6'b010101, 6'b001011};
    logic [5:0] want [4] = '{6'b111000, 6'b000110, 6'b000001, 6'b000000};
    bad = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if ((c & care[k]) == want[k]) begin bad = 1'b0; return k; end
    end
    return 0;
  endfunction

  function automatic logic [5:0] exp_touch(logic [5:0] c, int k);
    logic [5:0] setm [4] = '{6'b000000, 6'b100000, 6'b010100, 6'b001011};
    logic [5:0] clrm [4] = '{6'b111000, 6'b000110, 6'b000001, 6'b000000};
    return (c & ~clrm[k]) | setm[k];
  endfunction

  task automatic access(input string req, input int vpn, input int asid, input bit aen,
                        input bit ren, input bit uth, input bit utm,
                        input bit ush, input int uasid);
    int  cnt, first, vic;
    bit  bad, e_hit, e_miss, e_multi, e_ut, wr;
    int  e_idx;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VPN_W'(vpn); cur_asid = ASID_W'(asid);
    asid_en = aen; refill_en = ren; ut_hit = uth; ut_multi = utm;
    ut_shared = ush; ut_asid = ASID_W'(uasid);
    ctrl_we = g_we; ctrl_wcode = g_wcode;
    cnt = 0; first = -1;
    for (int k = 0; k < 4; k++) begin
      if (m_v[k] && m_vpn[k] == vpn && (m_sh[k] || !aen || m_as[k] == asid)) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
    vic = exp_victim(m_code, bad);
    e_hit = 0; e_miss = 0; e_multi = 0; e_ut = 0; wr = 0; e_idx = 0;
    if (cnt > 1) e_multi = 1;
    else if (cnt == 1) begin e_hit = 1; e_idx = first; end
    else if (!ren) e_miss = 1;
    else begin
      e_ut = 1;
      if (utm) e_multi = 1;
      else if (uth) begin e_hit = 1; e_idx = vic; wr = 1; end
      else e_miss = 1;
    end
    #2;
    chk(req, "hit", hit, e_hit);
    chk(req, "miss", miss, e_miss);
    chk(req, "multi_hit", multi_hit, e_multi);
    chk(req, "ut_req", ut_req, e_ut);
    chk(req, "lru_err", lru_err, bad);
    if (e_hit) chk(req, "hit_idx", hit_idx, e_idx);
    if (e_ut) chk(req, "ut_vpn", ut_vpn, vpn);
    @(posedge clk);
    if (wr) begin
      m_v[vic] = 1; m_sh[vic] = ush; m_as[vic] = uasid; m_vpn[vic] = vpn;
    end
    if (g_we) m_code = g_wcode;
    else if (e_hit) m_code = exp_touch(m_code, e_idx);
    @(negedge clk);
    req_valid = 1'b0; ctrl_we = 1'b0;
    #2;
    chk(req, "code after access", ctrl_rdata, {m_code, 26'b0});
  endtask

  task automatic load_code(input logic [5:0] c);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wcode = c;
    @(posedge clk);
    m_code = c;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_v[k] = 0; m_sh[k] = 0; m_as[k] = 0; m_vpn[k] = 0; end
    m_code = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "ctrl_rdata at reset", ctrl_rdata, 0);
    chk("R1", "hit idle", hit, 0);
    chk("R1", "lru_err at reset", lru_err, 0);
    rst_n = 1'b1;
    // R1/R7: empty buffer misses, no refill request
    access("R7", 5, 0, 1, 0, 0, 0, 0, 0);
    // R6: fill four slots (victims 3,2,1,0 from reset code)
    access("R6", 'h10, 1, 1, 1, 1, 0, 0, 1);
    access("R6", 'h11, 1, 1, 1, 1, 0, 1, 2);
    access("R6", 'h12, 1, 1, 1, 1, 0, 0, 3);
    access("R6", 'h13, 1, 1, 1, 1, 0, 0, 1);
    chk("R6", "slot3 vpn", m_vpn[3], 'h10);
    // R2: ASID / shared rules
    access("R2", 'h10, 1, 1, 0, 0, 0, 0, 0);
    access("R2", 'h10, 2, 1, 0, 0, 0, 0, 0);
    access("R2", 'h10, 2, 0, 0, 0, 0, 0, 0);
    access("R2", 'h11, 7, 1, 0, 0, 0, 0, 0);
    access("R2", 'h12, 9, 1, 0, 0, 0, 0, 0);
    // R3: build an alias then hit it with ASID matching off
    access("R6", 'h10, 2, 1, 1, 1, 0, 0, 2);
    access("R3", 'h10, 2, 0, 1, 1, 0, 0, 0);
    access("R3", 'h10, 1, 0, 0, 0, 0, 0, 0);
    // R7: unified miss, then no entry written
    access("R7", 'h40, 0, 1, 1, 0, 0, 0, 0);
    access("R7", 'h40, 0, 1, 0, 0, 0, 0, 0);
    // R10: unified multi-hit, then no entry written
    access("R10", 'h41, 0, 1, 1, 1, 1, 0, 0);
    access("R10", 'h41, 0, 1, 0, 0, 0, 0, 0);
    // R5/R8: every code, victim shown by a forced refill
    for (int c = 0; c < 64; c++) begin
      load_code(6'(c));
      access("R5_R8", 'h100 + c, 0, 0, 1, 1, 0, 0, 0);
    end
    // R4: every code, hit on each entry
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 4; k++) begin
        load_code(6'(c));
        access("R4", m_vpn[k], 0, 0, 0, 0, 0, 0, 0);
      end
    end
    // R9: control write collides with a hit and wins
    g_we = 1'b1; g_wcode = 6'b101010;
    access("R9", m_vpn[2], 0, 0, 0, 0, 0, 0, 0);
    g_we = 1'b0;
    chk("R9", "low control bits", ctrl_rdata[25:0], 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule